// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Controller

This block moves data on behalf of a processor, one unit per request, by borrowing the system bus for a single read and a single write and then handing it back. There are two channels. Each channel holds a source pointer and a destination pointer, a 16-bit transfer count with its reload value, a transfer size of a byte or a 16-bit word, and a choice between stopping after the final transfer and restarting from the reload values. At most one of the two addresses advances after each unit; the other stays fixed, which suits copying from a peripheral data register into a buffer or from a buffer out to one.

Software programs a channel through a small register port and then enables it. Each channel picks its trigger from a shared vector of request strobes, or from a trigger bit in its own control register. A request is held as one pending flag until its unit has moved. When both channels have work, channel 0 wins. The bus side is a plain request/grant master with read and write strobes, a ready input for wait states and a size output. Each channel pulses its own interrupt line when its count runs out.

Top module: `dma2_steal`

## Requirements
- R1: When both channels have a pending request in the same idle cycle, channel 0 is moved first and channel 1 follows.
- R2: Each unit raises bus_req, waits in an arbitration cycle for bus_gnt, then spends at least one cycle with bus_rd (address = source) and at least one with bus_wr (address = destination), and drops bus_req afterwards; with grant and ready at once the write is on the bus two cycles after bus_req rises.
- R3: Control bit 1 selects the unit size (0 = byte, 1 = 16-bit word, shown on bus_word); an advancing pointer steps by 1 for bytes and by 2 for words, across a 20-bit address.
- R4: Control bit 2 makes the source advance and bit 3 the destination; with both set the source advances, the destination stays fixed and control readback bit 9 reads 1.
- R5: The first unit after the enable bit (control bit 0) goes from 0 to 1 takes the advancing pointer from its base register and the count from the reload register; a reload value of N gives N+1 units before the count runs out.
- R6: With control bit 4 at 0 (stop mode), the unit that runs the count out clears the enable bit, and later requests move nothing.
- R7: With control bit 4 at 1 (restart mode), running out reloads both the count and the advancing pointer, and units continue.
- R8: Each run-out produces a one-cycle pulse on that channel's irq line, in the cycle after the final write is accepted.
- R9: Clearing the enable bit while a unit is waiting or in progress abandons it: no write for that unit appears on the bus and bus_req drops.
- R10: Control bits 7:5 choose the trigger: value 0 selects the software trigger (writing control with bit 8 set while the channel is already enabled), value k selects req_src[k]; requests to a disabled channel are ignored.
- R11: Requests that arrive while a channel's unit is already pending or moving collapse into a single pending unit.
- R12: Register select values (reg_addr[2:0]): 0 source base, 1 destination base, 2 reload, 3 control, 4 current count, 5 current advancing pointer; reg_addr[3] picks the channel; all read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel in bit 3, register select in bits 2:0 |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Register read data for reg_addr |
| req_src | input | 8 | Shared request strobes, one cycle each |
| bus_req | output | 1 | Bus request, held for a whole unit |
| bus_gnt | input | 1 | Bus grant |
| bus_rdy | input | 1 | Current read or write phase completes |
| bus_rd | output | 1 | Read phase strobe |
| bus_wr | output | 1 | Write phase strobe |
| bus_word | output | 1 | 1 for a 16-bit unit, 0 for a byte |
| bus_addr | output | 20 | Source address in the read phase, destination otherwise |
| bus_wdata | output | 16 | Write data captured in the read phase |
| bus_rdata | input | 16 | Read data, low byte used for byte units |
| irq | output | 2 | Per-channel run-out pulse |

## Verification
A request strobe sampled at one edge becomes pending at that edge, the arbitration cycle begins one edge later, the read phase one edge after grant and the write one edge after that, so with an open bus the write is seen four edges after the strobe and the run-out pulse five edges after it. The bench gives every stimulus a fixed settling window longer than that chain before it reads counters kept by a bus model, and it measures the two short gaps directly, bus_req rise to write and write to irq, as cycle differences. Register readback is combinational and is sampled a delay after the address is set on a falling edge.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  localparam int ADDR_W = 20;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 16;
  localparam int REG_W  = 20;
  localparam int SEL_W  = 3;
  localparam int NSRC   = 1 << SEL_W;
  localparam int NUM_CH = 2;
  localparam int CH_W   = 1;
  localparam int TRIG_BIT = 8;

  localparam logic [2:0] RS_SAR    = 3'd0;
  localparam logic [2:0] RS_DAR    = 3'd1;
  localparam logic [2:0] RS_RELOAD = 3'd2;
  localparam logic [2:0] RS_CTRL   = 3'd3;
  localparam logic [2:0] RS_COUNT  = 3'd4;
  localparam logic [2:0] RS_PTR    = 3'd5;

  typedef struct packed {
    logic [SEL_W-1:0] src_sel;
    logic             rpt;
    logic             dst_fwd;
    logic             src_fwd;
    logic             word;
    logic             en;
  } ctrl_t;

  typedef enum logic [1:0] {MV_IDLE, MV_ARB, MV_RD, MV_WR} mv_state_e;

  // Advance an address by one unit: 2 for words, 1 for bytes.
  function automatic logic [ADDR_W-1:0] ptr_step(input logic [ADDR_W-1:0] p,
                                                 input logic word);
    return p + {{(ADDR_W-2){1'b0}}, word, ~word};
  endfunction

  function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] c);
    return c - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  // Byte units keep only the low lane of the read data.
  function automatic logic [DATA_W-1:0] lane_fit(input logic [DATA_W-1:0] d,
                                                 input logic word);
    return word ? d : {8'h00, d[7:0]};
  endfunction
endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
  import dma2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [NSRC-1:0]   req_src,
  input  logic              xfer_done,
  output logic              en,
  output logic              pend,
  output logic              word,
  output logic              rpt,
  output logic              uflow_ev,
  output logic              irq,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [REG_W-1:0]  rd_data
);
  logic [ADDR_W-1:0] sar_q, dar_q, ptr_q;
  logic [CNT_W-1:0]  reload_q, cnt_q;
  ctrl_t             ctrl_q;
  logic              need_load_q;

  logic              wr_ctrl, sw_trig, req_sel, req_hit, en_rise, err;
  logic [ADDR_W-1:0] base, ptr_eff;
  logic [CNT_W-1:0]  cnt_eff;
  logic              ran_out, hw_stop, pend_n;

  assign wr_ctrl = cfg_we && (cfg_sel == RS_CTRL);
  assign sw_trig = wr_ctrl && cfg_wdata[TRIG_BIT];
  assign req_sel = (ctrl_q.src_sel == '0) ? sw_trig : req_src[ctrl_q.src_sel];
  assign req_hit = req_sel && ctrl_q.en;
  assign en_rise = wr_ctrl && cfg_wdata[0] && !ctrl_q.en;

  assign base    = ctrl_q.src_fwd ? sar_q : dar_q;
  assign ptr_eff = need_load_q ? base : ptr_q;
  assign cnt_eff = need_load_q ? reload_q : cnt_q;
  assign ran_out = (cnt_eff == '0);
  assign hw_stop = xfer_done && ran_out && !ctrl_q.rpt;
  assign err     = ctrl_q.src_fwd && ctrl_q.dst_fwd;

  assign src_addr = ctrl_q.src_fwd ? ptr_eff : sar_q;
  assign dst_addr = (ctrl_q.dst_fwd && !ctrl_q.src_fwd) ? ptr_eff : dar_q;

  assign en       = ctrl_q.en;
  assign word     = ctrl_q.word;
  assign rpt      = ctrl_q.rpt;
  assign uflow_ev = xfer_done && ran_out;

  // Pending: one flag, kept until its unit completes, lost on disable.
  assign pend_n = ((pend && !xfer_done) || req_hit) && ctrl_q.en && !hw_stop &&
                  !(wr_ctrl && !cfg_wdata[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sar_q       <= '0;
      dar_q       <= '0;
      ptr_q       <= '0;
      reload_q    <= '0;
      cnt_q       <= '0;
      ctrl_q      <= '0;
      need_load_q <= 1'b0;
      pend        <= 1'b0;
      irq         <= 1'b0;
    end else begin
      pend <= pend_n;
      irq  <= xfer_done && ran_out;
      if (xfer_done) begin
        need_load_q <= 1'b0;
        if (ran_out && ctrl_q.rpt) begin
          cnt_q <= reload_q;
          ptr_q <= base;
        end else begin
          cnt_q <= cnt_dec(cnt_eff);
          ptr_q <= ptr_step(ptr_eff, ctrl_q.word);
        end
        if (hw_stop && !wr_ctrl) ctrl_q.en <= 1'b0;
      end
      if (cfg_we) begin
        case (cfg_sel)
          RS_SAR:    sar_q    <= cfg_wdata[ADDR_W-1:0];
          RS_DAR:    dar_q    <= cfg_wdata[ADDR_W-1:0];
          RS_RELOAD: reload_q <= cfg_wdata[CNT_W-1:0];
          RS_CTRL: begin
            ctrl_q <= ctrl_t'(cfg_wdata[7:0]);
            if (en_rise) need_load_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (cfg_sel)
      RS_SAR:    rd_data = sar_q;
      RS_DAR:    rd_data = dar_q;
      RS_RELOAD: rd_data = {{(REG_W-CNT_W){1'b0}}, reload_q};
      RS_CTRL:   rd_data = {{(REG_W-10){1'b0}}, err, 1'b0, ctrl_q};
      RS_COUNT:  rd_data = {{(REG_W-CNT_W){1'b0}}, cnt_q};
      RS_PTR:    rd_data = ptr_q;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dma2_arb.sv
module dma2_arb
  import dma2_pkg::*;
(
  input  logic [NUM_CH-1:0] ready,
  output logic              any,
  output logic [CH_W-1:0]   pick
);
  // Walk from the highest index down so the lowest ready index wins.
  always_comb begin
    any  = |ready;
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (ready[i]) pick = CH_W'(i);
    end
  end
endmodule

// File: rtl/dma2_mover.sv
module dma2_mover
  import dma2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any,
  input  logic [CH_W-1:0]   pick,
  input  logic [NUM_CH-1:0] en_vec,
  input  logic [ADDR_W-1:0] act_src,
  input  logic [ADDR_W-1:0] act_dst,
  input  logic              act_word,
  input  logic              bus_gnt,
  input  logic              bus_rdy,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [CH_W-1:0]   act,
  output logic              busy,
  output logic              start_ev,
  output logic              done_ev,
  output logic              abort_ev,
  output logic              bus_req,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_word,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata
);
  mv_state_e         state_q;
  logic [DATA_W-1:0] data_q;

  assign busy     = (state_q != MV_IDLE);
  assign start_ev = (state_q == MV_IDLE) && any;
  assign abort_ev = busy && !en_vec[act];
  assign done_ev  = (state_q == MV_WR) && bus_rdy && !abort_ev;

  assign bus_req   = busy;
  assign bus_rd    = (state_q == MV_RD);
  assign bus_wr    = (state_q == MV_WR);
  assign bus_word  = act_word;
  assign bus_addr  = (state_q == MV_WR) ? act_dst : act_src;
  assign bus_wdata = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      act     <= '0;
      data_q  <= '0;
    end else if (abort_ev) begin
      state_q <= MV_IDLE;
    end else begin
      case (state_q)
        MV_IDLE: if (any) begin
          act     <= pick;
          state_q <= MV_ARB;
        end
        MV_ARB:  if (bus_gnt) state_q <= MV_RD;
        MV_RD:   if (bus_rdy) begin
          data_q  <= lane_fit(bus_rdata, act_word);
          state_q <= MV_WR;
        end
        MV_WR:   if (bus_rdy) state_q <= MV_IDLE;
        default: state_q <= MV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma2_steal.sv
module dma2_steal
  import dma2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NSRC-1:0]   req_src,
  output logic              bus_req,
  input  logic              bus_gnt,
  input  logic              bus_rdy,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_word,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH-1:0] en_vec, pend_vec, word_vec, rpt_vec, uflow_vec, rdy_vec, done_vec;
  logic [ADDR_W-1:0] src_vec [NUM_CH];
  logic [ADDR_W-1:0] dst_vec [NUM_CH];
  logic [REG_W-1:0]  rd_vec  [NUM_CH];

  logic            any, busy, start_ev, done_ev, abort_ev;
  logic [CH_W-1:0] start_pick, act;

  assign rdy_vec = pend_vec & en_vec;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign done_vec[i] = done_ev && (act == CH_W'(i));
    dma2_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (reg_we && (reg_addr[3] == 1'(i))),
      .cfg_sel  (reg_addr[2:0]),
      .cfg_wdata(reg_wdata),
      .req_src  (req_src),
      .xfer_done(done_vec[i]),
      .en       (en_vec[i]),
      .pend     (pend_vec[i]),
      .word     (word_vec[i]),
      .rpt      (rpt_vec[i]),
      .uflow_ev (uflow_vec[i]),
      .irq      (irq[i]),
      .src_addr (src_vec[i]),
      .dst_addr (dst_vec[i]),
      .rd_data  (rd_vec[i])
    );
  end

  assign reg_rdata = rd_vec[reg_addr[3]];

  dma2_arb u_arb (
    .ready(rdy_vec),
    .any  (any),
    .pick (start_pick)
  );

  dma2_mover u_mover (
    .clk      (clk),
    .rst_n    (rst_n),
    .any      (any),
    .pick     (start_pick),
    .en_vec   (en_vec),
    .act_src  (src_vec[act]),
    .act_dst  (dst_vec[act]),
    .act_word (word_vec[act]),
    .bus_gnt  (bus_gnt),
    .bus_rdy  (bus_rdy),
    .bus_rdata(bus_rdata),
    .act      (act),
    .busy     (busy),
    .start_ev (start_ev),
    .done_ev  (done_ev),
    .abort_ev (abort_ev),
    .bus_req  (bus_req),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_word (bus_word),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata)
  );
endmodule

// File: rtl/dma2_chk.sv
module dma2_chk
  import dma2_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              bus_req,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [NUM_CH-1:0] irq,
  input logic              start_ev,
  input logic [CH_W-1:0]   start_pick,
  input logic [NUM_CH-1:0] rdy_vec,
  input logic              busy,
  input logic [CH_W-1:0]   act,
  input logic [NUM_CH-1:0] en_vec,
  input logic [NUM_CH-1:0] uflow_vec,
  input logic [NUM_CH-1:0] rpt_vec
);
  assert_ch0_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && rdy_vec == 2'b11) |-> (start_pick == '0));

  assert_strobe_in_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> bus_req);

  assert_write_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |-> $past(bus_rd));

  assert_abort_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !en_vec[act]) |=> (!bus_rd && !bus_wr));

  assert_start_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |-> en_vec[start_pick]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_stop_clears_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow_vec[i] && !rpt_vec[i] && !reg_we) |=> !en_vec[i]);

    assert_irq_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |=> !irq[i]);

    assert_irq_after_runout_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> $past(uflow_vec[i]));
  end
endmodule

bind dma2_steal dma2_chk u_chk (.*);

// File: tb/dma2_steal_bench.sv
module dma2_steal_bench;
  import dma2_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [3:0]        reg_addr = '0;
  logic [REG_W-1:0]  reg_wdata = '0;
  logic [REG_W-1:0]  reg_rdata;
  logic [NSRC-1:0]   req_src = '0;
  logic              bus_req, bus_rd, bus_wr, bus_word;
  logic              gnt_ok = 1'b1;
  logic              bus_gnt;
  logic              bus_rdy = 1'b1;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic [NUM_CH-1:0] irq;

  always #4 clk = ~clk;

  dma2_steal u_dma2_steal (.*);

  assign bus_gnt = gnt_ok && bus_req;

  // Bus model: 4 KiB little-endian memory plus event counters.
  logic [7:0]  mem [4096];
  logic        clr = 1'b0;
  int          cyc = 0, wr_cnt = 0, irq_cnt = 0, irq_gap = 0;
  int          last_wr_cyc = 0, req_rise_cyc = 0;
  logic [19:0] last_wr_addr = '0, first_wr_addr = '0;
  logic        req_q = 1'b0;

  function automatic logic [7:0] pat(input logic [19:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  assign bus_rdata = {mem[bus_addr[11:0] + 12'd1], mem[bus_addr[11:0]]};

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] = pat(20'(i));
    end
    if (clr) begin
      wr_cnt = 0; irq_cnt = 0;
    end else begin
      if (bus_wr && bus_rdy) begin
        if (wr_cnt == 0) first_wr_addr = bus_addr;
        wr_cnt = wr_cnt + 1;
        last_wr_addr = bus_addr;
        last_wr_cyc = cyc;
        mem[bus_addr[11:0]] = bus_wdata[7:0];
        if (bus_word) mem[bus_addr[11:0] + 12'd1] = bus_wdata[15:8];
      end
      if (irq[0] || irq[1]) begin
        irq_cnt = irq_cnt + 1;
        irq_gap = cyc - last_wr_cyc;
      end
    end
    if (bus_req && !req_q) req_rise_cyc = cyc;
    req_q = bus_req;
  end

  int n_chk = 0, n_fail = 0;
  bit done_flag = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic ch, input logic [2:0] sel, input logic [19:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {ch, sel}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic ch, input logic [2:0] sel, output logic [19:0] d);
    @(negedge clk);
    reg_addr = {ch, sel};
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [NSRC-1:0] m);
    @(negedge clk);
    req_src = m;
    @(negedge clk);
    req_src = '0;
  endtask

  task automatic clear_counts();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  typedef struct packed {
    logic [19:0] sar, dar;
    logic [15:0] reload;
    logic [7:0]  ctrl, ntrig, nwr, nirq;
    logic [19:0] last_dst, last_src;
  } vec_t;

  // ctrl: en=bit0 word=bit1 src_fwd=bit2 dst_fwd=bit3 rpt=bit4, trigger select 1 (bits 7:5)
  localparam vec_t VECS [5] = '{
    '{20'h00010, 20'h00800, 16'd3, 8'h25, 8'd4, 8'd4, 8'd1, 20'h00800, 20'h00013},
    '{20'h00020, 20'h00900, 16'd2, 8'h2B, 8'd3, 8'd3, 8'd1, 20'h00904, 20'h00020},
    '{20'h00030, 20'h00A00, 16'd1, 8'h35, 8'd5, 8'd5, 8'd2, 20'h00A00, 20'h00030},
    '{20'h00040, 20'h00A10, 16'd0, 8'h2D, 8'd1, 8'd1, 8'd1, 20'h00A10, 20'h00040},
    '{20'h00050, 20'h00A20, 16'd1, 8'h25, 8'd4, 8'd2, 8'd1, 20'h00A20, 20'h00051}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [19:0] rd;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);

    // Reset state (R12, R2, R8)
    chk("R2 bus_req after reset", 32'(bus_req), 0);
    chk("R8 irq after reset", 32'(irq), 0);
    rreg(1'b0, RS_CTRL, rd);
    chk("R12 ctrl reads 0 after reset", 32'(rd), 0);

    // Table of vectors on channel 0 (R3 R4 R5 R6 R7 R8)
    for (int v = 0; v < 5; v++) begin
      wreg(1'b0, RS_CTRL, 20'h0);
      wreg(1'b0, RS_SAR, VECS[v].sar);
      wreg(1'b0, RS_DAR, VECS[v].dar);
      wreg(1'b0, RS_RELOAD, 20'(VECS[v].reload));
      clear_counts();
      wreg(1'b0, RS_CTRL, 20'(VECS[v].ctrl));
      for (int t = 0; t < int'(VECS[v].ntrig); t++) begin
        pulse(8'h02);
        wait_n(8);
      end
      chk($sformatf("R5 R6 R7 vec%0d units moved", v), wr_cnt, 32'(VECS[v].nwr));
      chk($sformatf("R8 vec%0d run-out pulses", v), irq_cnt, 32'(VECS[v].nirq));
      chk($sformatf("R8 vec%0d irq one cycle after write", v), irq_gap, 1);
      chk($sformatf("R3 R4 vec%0d last destination", v), 32'(last_wr_addr), 32'(VECS[v].last_dst));
      chk($sformatf("R3 vec%0d data copied", v), 32'(mem[VECS[v].last_dst[11:0]]),
          32'(pat(VECS[v].last_src)));
      if (VECS[v].ctrl[1])
        chk("R3 word upper byte", 32'(mem[VECS[v].last_dst[11:0] + 12'd1]),
            32'(pat(VECS[v].last_src + 20'd1)));
      rreg(1'b0, RS_CTRL, rd);
      if (VECS[v].ctrl[3:2] == 2'b11) chk("R4 both-advance flag", 32'(rd[9]), 1);
      if (!VECS[v].ctrl[4]) chk("R6 enable cleared at run-out", 32'(rd[0]), 0);
      else                  chk("R7 restart keeps enable", 32'(rd[0]), 1);
    end

    // R12: count and pointer readback after one unit
    wreg(1'b0, RS_CTRL, 20'h0);
    wreg(1'b0, RS_SAR, 20'h00060);
    wreg(1'b0, RS_DAR, 20'h00B40);
    wreg(1'b0, RS_RELOAD, 20'd5);
    wreg(1'b0, RS_CTRL, 20'h25);
    clear_counts();
    pulse(8'h02);
    wait_n(8);
    rreg(1'b0, RS_COUNT, rd);
    chk("R12 count after one unit", 32'(rd), 4);
    rreg(1'b0, RS_PTR, rd);
    chk("R12 pointer after one unit", 32'(rd), 32'h61);
    // R2: write two cycles after bus_req rises
    chk("R2 req-to-write cycles", last_wr_cyc - req_rise_cyc, 2);
    chk("R2 bus returned", 32'(bus_req), 0);

    // R1: both channels pending together
    wreg(1'b1, RS_SAR, 20'h00080);
    wreg(1'b1, RS_DAR, 20'h00B10);
    wreg(1'b1, RS_RELOAD, 20'd5);
    wreg(1'b1, RS_CTRL, 20'h45);
    wreg(1'b0, RS_DAR, 20'h00B00);
    gnt_ok = 1'b0;
    clear_counts();
    pulse(8'h06);
    wait_n(3);
    gnt_ok = 1'b1;
    wait_n(12);
    chk("R1 two units", wr_cnt, 2);
    chk("R1 channel 0 first", 32'(first_wr_addr), 32'hB00);
    chk("R1 channel 1 second", 32'(last_wr_addr), 32'hB10);

    // R11: repeated requests while waiting collapse to one
    gnt_ok = 1'b0;
    clear_counts();
    pulse(8'h02); pulse(8'h02); pulse(8'h02);
    gnt_ok = 1'b1;
    wait_n(12);
    chk("R11 collapsed requests", wr_cnt, 1);

    // R9: disable while waiting for grant
    gnt_ok = 1'b0;
    clear_counts();
    pulse(8'h02);
    wait_n(3);
    chk("R9 waiting for bus", 32'(bus_req), 1);
    wreg(1'b0, RS_CTRL, 20'h24);
    gnt_ok = 1'b1;
    wait_n(8);
    chk("R9 no write after disable", wr_cnt, 0);
    chk("R9 bus_req dropped", 32'(bus_req), 0);

    // R10: disabled channel ignores its source; software trigger
    clear_counts();
    pulse(8'h02);
    wait_n(8);
    chk("R10 disabled request ignored", wr_cnt, 0);
    wreg(1'b1, RS_CTRL, 20'h0);
    wreg(1'b1, RS_CTRL, 20'h005);
    pulse(8'h02);
    wait_n(8);
    chk("R10 hardware strobe ignored with select 0", wr_cnt, 0);
    wreg(1'b1, RS_CTRL, 20'h105);
    wait_n(8);
    chk("R10 software trigger moves one unit", wr_cnt, 1);
    chk("R10 software unit from channel 1 base", 32'(last_wr_addr), 32'hB10);

    finish_run();
  end
endmodule